// File: doc/BRIEF.md
# Oversampling UART Receive Recovery

This block is the front end of a UART receiver. It watches a raw serial line and decides every bit by a majority vote over three oversampled points at the middle of the bit. The time base is an oversampling tick supplied from outside. In normal mode one bit time spans 16 ticks. In double-speed mode it spans 8 ticks. When the line falls from high to low, the block takes that tick as sample 1 of a candidate start bit. Three samples at the middle of the start bit then confirm it or reject it as a glitch. Bit timing is aligned again on every start bit, so each frame is timed on its own.

Once a start bit is confirmed, the block gathers a configurable number of data bits, least significant bit first. It then takes an optional parity bit and checks the first stop bit only. When the stop bit is decided, the block presents the assembled word, the received parity bit and a frame-error flag together with a one-cycle strobe. It then waits in idle for the next falling edge.

The output is a strobe and has no ready signal. A serial line cannot be paused, so the block has no back-pressure. A consumer must accept the word in the cycle the strobe is high. Between strobes, the word, the parity bit and the flag keep their last values.

Top module: `uart_rx_recover`

## Requirements
- R1: After reset, rx_valid, rx_word, rx_par and rx_ferr are all 0.
- R2: A frame begins only at a tick where the synchronised line is low and the previous tick in idle saw it high. A line that is already low when the receiver is enabled starts nothing until it has first been seen high.
- R3: The start bit is confirmed by the majority of its three centre samples. If two or more of them are high, no frame is produced and the receiver goes back to idle.
- R4: With dbl_speed=0 a bit lasts 16 ticks and is voted on samples 8, 9 and 10. With dbl_speed=1 it lasts 8 ticks and is voted on samples 4, 5 and 6. The tick of the falling edge is sample 1. A wrong value in any single sample, or anywhere outside the three centre samples, does not change the decided bit.
- R5: cfg_len data bits (1 to MAX_BITS) are placed into rx_word in arrival order. The first bit received goes to bit 0. Bits at position cfg_len and above read as 0.
- R6: When cfg_par=1, one parity bit follows the data and its voted value appears on rx_par. When cfg_par=0, no parity bit is expected and rx_par is 0.
- R7: Only the first stop bit is checked. rx_ferr is set to 1 if two or more of its centre samples are low, and to 0 otherwise. It is updated with every word, and the word is delivered in both cases.
- R8: rx_valid is high for exactly one clock cycle. That cycle is the one after the tick of the stop bit's last centre sample, which is tick start + (1+cfg_len+cfg_par)·N + N/2+1, where N is the bit length in ticks.
- R9: After the stop bit is decided, the receiver returns to idle. A frame that starts right after the stop bit, or after an idle gap of any number of ticks, is received correctly.
- R10: Clearing rx_en forces the receiver to idle and drops any partly received frame, with no strobe. The next frame after rx_en is set again is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low holds the receiver in idle |
| dbl_speed | input | 1 | 0: 16 ticks per bit; 1: 8 ticks per bit |
| cfg_len | input | LEN_W | Number of data bits per frame, 1..MAX_BITS |
| cfg_par | input | 1 | 1: a parity bit follows the data |
| s_tick | input | 1 | Oversampling tick, one clock cycle wide |
| rxd | input | 1 | Raw serial input, idle high |
| rx_valid | output | 1 | One-cycle strobe: a frame has completed |
| rx_word | output | MAX_BITS | Received data, right-justified |
| rx_par | output | 1 | Received parity bit |
| rx_ferr | output | 1 | Stop bit was voted low |

## Verification
The bench sweeps both oversampling ratios, every frame length from 5 to 9 bits, and parity on and off. Each frame carries one wrong sample, placed either inside the centre window, where the vote must outvote it, or outside it, where it must be ignored. Together these show whether the window position and the bit length are right in each mode. Separate patterns cover the cases that tell a correct receiver from a nearly correct one: a start glitch that fails its vote, a stop bit with two low centre samples, frames sent with no gap and with an odd gap to test re-alignment, a line held low across enable, and a disable in the middle of a frame. Every delivered word is also checked for its exact strobe tick.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } rx_phase_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // reset to the idle level of the line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_sample_ctr.sv
module rx_sample_ctr #(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8,
  localparam int CW = $clog2(OSR_NORM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,     // this tick is sample 1 of a start bit
  input  logic          run,
  input  logic          tick,
  input  logic          dbl,
  output logic [CW-1:0] num       // number of the sample taken at this tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = dbl ? CW'(OSR_FAST) : CW'(OSR_NORM);
  assign num = (cnt >= lim) ? CW'(1) : cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= CW'(1);
    else if (!run) cnt <= '0;
    else if (tick) cnt <= num;
  end

  // R4: the count never exceeds one bit time
  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(OSR_NORM));
endmodule

// File: rtl/rx_vote.sv
module rx_vote #(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8,
  localparam int CW = $clog2(OSR_NORM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          dbl,
  input  logic [CW-1:0] num,
  input  logic          sample,
  output logic          decide,
  output logic          bit_val
);
  import uart_rx_pkg::*;

  localparam logic [CW-1:0] LO_NORM = CW'(OSR_NORM / 2);
  localparam logic [CW-1:0] LO_FAST = CW'(OSR_FAST / 2);

  logic [CW-1:0] lo;
  logic          s_first, s_second;

  assign lo      = dbl ? LO_FAST : LO_NORM;
  assign decide  = tick && (num == lo + CW'(2));
  assign bit_val = maj3(s_first, s_second, sample);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_first  <= 1'b1;
      s_second <= 1'b1;
    end else if (tick) begin
      if (num == lo)          s_first  <= sample;
      if (num == lo + CW'(1)) s_second <= sample;
    end
  end

  // R4: a decision only happens inside a bit, never on sample 1
  a_r4_decide_mid: assert property (@(posedge clk) disable iff (!rst_n)
    decide |-> (num > CW'(2)));
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int W = 9,
  localparam int IW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr,
  input  logic [IW-1:0] idx,
  input  logic          din,
  output logic [W-1:0]  word
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      word[i] <= 1'b0;
      else if (clear)                  word[i] <= 1'b0;
      else if (wr && idx == IW'(i))    word[i] <= din;
    end
  end
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover #(
  parameter int MAX_BITS    = 9,
  parameter int OSR_NORM    = 16,
  parameter int OSR_FAST    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W = $clog2(MAX_BITS + 1),
  localparam int CW    = $clog2(OSR_NORM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                dbl_speed,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_par,
  input  logic                s_tick,
  input  logic                rxd,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                rx_par,
  output logic                rx_ferr
);
  import uart_rx_pkg::*;

  rx_phase_e         phase;
  logic              rxs;
  logic              prev_hi;
  logic [LEN_W-1:0]  didx;
  logic [LEN_W-1:0]  len_eff;
  logic              par_bit;
  logic [CW-1:0]     num;
  logic              decide, bit_val;
  logic              start_hit;
  logic [MAX_BITS-1:0] word;

  // data length clamped into 1..MAX_BITS
  assign len_eff = (cfg_len == '0) ? LEN_W'(1) :
                   (cfg_len > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : cfg_len;

  assign start_hit = rx_en && (phase == PH_IDLE) && s_tick && prev_hi && !rxs;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
  );

  rx_sample_ctr #(.OSR_NORM(OSR_NORM), .OSR_FAST(OSR_FAST)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start_hit),
    .run(rx_en && phase != PH_IDLE), .tick(s_tick), .dbl(dbl_speed), .num(num)
  );

  rx_vote #(.OSR_NORM(OSR_NORM), .OSR_FAST(OSR_FAST)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(s_tick), .dbl(dbl_speed), .num(num),
    .sample(rxs), .decide(decide), .bit_val(bit_val)
  );

  rx_shifter #(.W(MAX_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(start_hit || !rx_en),
    .wr(decide && phase == PH_DATA), .idx(didx), .din(bit_val), .word(word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      prev_hi  <= 1'b0;
      didx     <= '0;
      par_bit  <= 1'b0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
      rx_par   <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!rx_en) begin
        phase   <= PH_IDLE;
        prev_hi <= 1'b0;
        didx    <= '0;
        par_bit <= 1'b0;
      end else begin
        unique case (phase)
          PH_IDLE: begin
            if (s_tick) begin
              prev_hi <= rxs;
              if (prev_hi && !rxs) begin
                phase   <= PH_START;
                didx    <= '0;
                par_bit <= 1'b0;
              end
            end
          end
          PH_START: begin
            if (decide) begin
              if (!bit_val) phase <= PH_DATA;
              else begin
                phase   <= PH_IDLE;
                prev_hi <= rxs;
              end
            end
          end
          PH_DATA: begin
            if (decide) begin
              if (didx == len_eff - LEN_W'(1))
                phase <= cfg_par ? PH_PAR : PH_STOP;
              else
                didx <= didx + LEN_W'(1);
            end
          end
          PH_PAR: begin
            if (decide) begin
              par_bit <= bit_val;
              phase   <= PH_STOP;
            end
          end
          PH_STOP: begin
            if (decide) begin
              rx_valid <= 1'b1;
              rx_word  <= word;
              rx_par   <= cfg_par & par_bit;
              rx_ferr  <= !bit_val;
              phase    <= PH_IDLE;
              prev_hi  <= rxs;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // R8: the strobe lasts one cycle
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8: the strobe follows a tick
  a_r8_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(s_tick));

  // R10: disable parks the receiver with no strobe
  a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (phase == PH_IDLE && !rx_valid));

  // R6: parity output is 0 when no parity bit is configured
  a_r6_parity_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_par) |-> !rx_par);

  // R5: bits above the frame length read as zero
  a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_word >> len_eff) == '0));

  // R2: a frame starts only from a low sample on a tick
  a_r2_start_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_START && $past(phase == PH_IDLE)) |-> $past(s_tick && !rxs));
endmodule

// File: tb/sim_uart_rx_recover.sv
module sim_uart_rx_recover;
  localparam int MAXB = 9;
  localparam int LW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rx_en = 1'b0;
  logic            dbl_speed = 1'b0;
  logic [LW-1:0]   cfg_len = LW'(8);
  logic            cfg_par = 1'b0;
  logic            s_tick = 1'b0;
  logic            rxd = 1'b1;
  logic            rx_valid;
  logic [MAXB-1:0] rx_word;
  logic            rx_par, rx_ferr;

  int nchk = 0, nerr = 0;
  int tick_idx = 0;
  int vcount = 0, g_tick = 0;
  logic [MAXB-1:0] g_word;
  logic g_par, g_ferr;
  int start_tick = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_recover #(.MAX_BITS(MAXB)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dbl_speed(dbl_speed),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .s_tick(s_tick), .rxd(rxd),
    .rx_valid(rx_valid), .rx_word(rx_word), .rx_par(rx_par), .rx_ferr(rx_ferr)
  );

  always @(negedge clk) if (rx_valid) begin
    vcount++;
    g_word = rx_word; g_par = rx_par; g_ferr = rx_ferr; g_tick = tick_idx;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic samp(input logic v);
    @(negedge clk) rxd = v;
    repeat (2) @(negedge clk);
    s_tick = 1'b1; tick_idx++;
    @(negedge clk) s_tick = 1'b0;
  endtask

  // n samples of v, samples fa..fb inverted (fa=0: none)
  task automatic push_bit(input logic v, input int n, input int fa, input int fb);
    for (int k = 1; k <= n; k++) samp((fa != 0 && k >= fa && k <= fb) ? ~v : v);
  endtask

  task automatic frame(input int n, input int len, input bit pe, input int data,
                       input logic pb, input int flip, input int sfa, input int sfb);
    start_tick = tick_idx + 1;
    push_bit(1'b0, n, flip, flip);
    for (int i = 0; i < len; i++) push_bit(data[i], n, flip, flip);
    if (pe) push_bit(pb, n, flip, flip);
    push_bit(1'b1, n, sfa, sfb);
  endtask

  task automatic expect_frame(input string tag, input int n, input int len, input bit pe,
                              input int data, input logic pb, input logic ferr, input int vbefore);
    int exp_t;
    logic [MAXB-1:0] ew;
    ew = MAXB'(data & ((1 << len) - 1));
    exp_t = start_tick + (1 + len + int'(pe)) * n + n / 2 + 1;
    chk(vcount == vbefore + 1, {tag, " R8 strobe count"}, vcount, vbefore + 1);
    chk(g_word == ew, {tag, " R5 word"}, g_word, ew);
    chk(g_par == (pe & pb), {tag, " R6 parity"}, g_par, pe & pb);
    chk(g_ferr == ferr, {tag, " R7 ferr"}, g_ferr, ferr);
    chk(g_tick == exp_t, {tag, " R8 strobe tick"}, g_tick, exp_t);
  endtask

  task automatic config_rx(input bit dbl, input int len, input bit pe);
    @(negedge clk) rx_en = 1'b0;
    dbl_speed = dbl; cfg_len = LW'(len); cfg_par = pe; rxd = 1'b1;
    @(negedge clk) rx_en = 1'b1;
    push_bit(1'b1, 3, 0, 0);
  endtask

  initial begin
    int v0, n, d;
    repeat (3) @(negedge clk);
    chk(rx_valid == 0 && rx_word == 0 && rx_par == 0 && rx_ferr == 0,
        "R1 reset outputs", {rx_valid, rx_word, rx_par, rx_ferr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_valid == 0 && rx_word == 0, "R1 after release", {rx_valid, rx_word}, 0);

    // R4 R5 R6 sweep over modes, lengths, parity, flip position
    for (int m = 0; m < 2; m++)
      for (int len = 5; len <= 9; len++)
        for (int pe = 0; pe < 2; pe++)
          for (int p = 0; p < 2; p++) begin
            n = m ? 8 : 16;
            d = p ? ((len * 37 + 5) ^ 9'h0A5) : ((len * 91) ^ 9'h15A);
            config_rx(m[0], len, pe[0]);
            v0 = vcount;
            frame(n, len, pe[0], d, ^d[7:0], p ? 2 : n / 2 + 1, 0, 0);
            expect_frame($sformatf("sweep m%0d l%0d p%0d f%0d R4", m, len, pe, p),
                         n, len, pe[0], d, ^d[7:0], 1'b0, v0);
          end

    // R7 stop with two low centre samples, word still delivered
    config_rx(1'b0, 8, 1'b0);
    v0 = vcount;
    frame(16, 8, 1'b0, 8'h3C, 1'b0, 0, 9, 10);
    expect_frame("stop error R7", 16, 8, 1'b0, 8'h3C, 1'b0, 1'b1, v0);
    v0 = vcount;
    frame(16, 8, 1'b0, 8'hC5, 1'b0, 0, 0, 0);
    expect_frame("ferr cleared R7", 16, 8, 1'b0, 8'hC5, 1'b0, 1'b0, v0);

    // R3 start glitch in both modes
    v0 = vcount;
    push_bit(1'b0, 16, 9, 16);
    push_bit(1'b1, 20, 0, 0);
    chk(vcount == v0, "R3 glitch normal no strobe", vcount, v0);
    frame(16, 8, 1'b0, 8'h81, 1'b0, 0, 0, 0);
    expect_frame("after glitch R3", 16, 8, 1'b0, 8'h81, 1'b0, 1'b0, v0);
    config_rx(1'b1, 8, 1'b1);
    v0 = vcount;
    push_bit(1'b0, 8, 5, 8);
    push_bit(1'b1, 12, 0, 0);
    chk(vcount == v0, "R3 glitch fast no strobe", vcount, v0);

    // R9 back-to-back frames and re-alignment after an odd gap
    v0 = vcount;
    frame(8, 8, 1'b1, 8'h5A, 1'b1, 0, 0, 0);
    expect_frame("b2b first R9", 8, 8, 1'b1, 8'h5A, 1'b1, 1'b0, v0);
    v0 = vcount;
    frame(8, 8, 1'b1, 8'hA7, 1'b0, 0, 0, 0);
    expect_frame("b2b second R9", 8, 8, 1'b1, 8'hA7, 1'b0, 1'b0, v0);
    push_bit(1'b1, 5, 0, 0);
    v0 = vcount;
    frame(8, 8, 1'b1, 8'h0F, 1'b1, 0, 0, 0);
    expect_frame("odd gap R9", 8, 8, 1'b1, 8'h0F, 1'b1, 1'b0, v0);

    // R2 line low when enabled starts nothing
    @(negedge clk) rx_en = 1'b0;
    dbl_speed = 1'b0; cfg_len = LW'(8); cfg_par = 1'b0; rxd = 1'b0;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    v0 = vcount;
    push_bit(1'b0, 40, 0, 0);
    push_bit(1'b1, 4, 0, 0);
    chk(vcount == v0, "R2 held low no strobe", vcount, v0);
    frame(16, 8, 1'b0, 8'h99, 1'b0, 0, 0, 0);
    expect_frame("after held low R2", 16, 8, 1'b0, 8'h99, 1'b0, 1'b0, v0);

    // R10 disable in the middle of a frame
    v0 = vcount;
    push_bit(1'b0, 16, 0, 0);
    push_bit(1'b1, 16, 0, 0);
    push_bit(1'b0, 16, 0, 0);
    @(negedge clk) rx_en = 1'b0;
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    push_bit(1'b1, 20, 0, 0);
    chk(vcount == v0, "R10 no strobe after disable", vcount, v0);
    frame(16, 8, 1'b0, 8'h6E, 1'b0, 0, 0, 0);
    expect_frame("after re-enable R10", 16, 8, 1'b0, 8'h6E, 1'b0, 1'b0, v0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule